// File: doc/BRIEF.md
# Externally Clocked Double-Buffered Serial Transmitter

This block sends words out on a serial data line, one bit per shift clock. The shift clock is not produced here. A remote device drives it on `ckIn`, and the block only follows it. Each falling edge of `ckIn` moves the data line on to the next bit. The remote side samples the line on the rising edge. Words go out least-significant bit first. There are eight data bits, plus an optional ninth bit taken from a separate input.

Software writes words into a one-word holding register. The shift register loads from the holding register whenever it is free and transmission is enabled. A second word written while the first is still shifting waits in the holding register. The buffer-empty flag stays low while that word waits. The flag rises in the cycle the waiting word moves into the shift register. Combined with an interrupt enable, the flag drives an interrupt output. Dropping either the port enable or the transmit enable returns the shift logic to idle.

`ckIn` passes through a two-flop synchronizer and a falling-edge detector in the system clock domain. For this reason, each level of `ckIn` must last at least four system clock cycles.

Top module: `extclk_ser_tx`

## Requirements
- R1: After reset, `bufEmpty` is 1, `dtOut` is 1 (idle level) and `txIrq` is 0 while `intEn` is 0.
- R2: A write to an empty holding register while `portEn` and `txEn` are both 1 and nothing is shifting sets the holding register full (`bufEmpty` 0) at the first clock edge. The word moves to the shift register at the next edge. After that second edge, `bufEmpty` is 1 again and `dtOut` shows bit 0 of the word.
- R3: Bits leave least-significant bit first. `dtOut` advances to the next bit only after a falling edge of `ckIn`, within four system clocks. After the last bit, `dtOut` returns to 1.
- R4: When `wrNine` is 1 at the write, the word carries a ninth bit (bit index 8), equal to `wrBit9` at the write. When `wrNine` is 0, the word has exactly eight bits.
- R5: A word written while another is shifting stays in the holding register with `bufEmpty` at 0. On the falling edge that ends the current word, the held word moves into the shift register and `bufEmpty` rises. The two words appear on `dtOut` with no idle bit between them.
- R6: A write to a full holding register replaces the waiting word. The replaced word is never sent, and `bufEmpty` stays 0.
- R7: `txIrq` is 1 exactly when `intEn` is 1 and `bufEmpty` is 1.
- R8: While `txEn` is 0 (with `portEn` 1), nothing loads or shifts, `dtOut` is 1, and a word in shift is dropped. A word in the holding register is kept and is sent once `txEn` returns to 1.
- R9: While `portEn` is 0, the holding register is emptied (`bufEmpty` 1), writes are ignored and `dtOut` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ckIn | input | 1 | Shift clock from the remote device |
| portEn | input | 1 | Serial port enable |
| txEn | input | 1 | Transmit enable |
| wrStrobe | input | 1 | One-cycle write to the holding register |
| wrData | input | 8 | Data word to send |
| wrNine | input | 1 | Word is nine bits long when 1 |
| wrBit9 | input | 1 | Ninth bit value for the word |
| intEn | input | 1 | Interrupt enable |
| dtOut | output | 1 | Serial data line |
| bufEmpty | output | 1 | Holding register is empty |
| txIrq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the hand-off at the falling edge that ends one word. At that edge, a waiting word must load in the same cycle, with no idle bit on the line. A stacked overwrite makes it harder still. To get there, the bench writes the next word, or two words in a row, while the current word is still shifting. It then clocks `ckIn` through the whole stream, checking the flag just before and just after that edge. Mixed 8- and 9-bit words with random data run in both single and double-buffered patterns. The bench compares every word, bit by bit, against an expected bit function.

// File: rtl/extclk_ser_tx_pkg.sv
package extclk_ser_tx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;   // move holding word into shift register
    logic shift;  // advance shift register by one bit
    logic clear;  // return shift register to idle
  } txStrobe_t;
endpackage

// File: rtl/extclk_ck_sync.sv
module extclk_ck_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ckIn,
  output logic fallPulse
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  // idle level of the external clock is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[CHAIN_W-2:0], ckIn};
  end

  assign fallPulse = chain[CHAIN_W-1] & ~chain[CHAIN_W-2];
endmodule

// File: rtl/extclk_tx_ctrl.sv
module extclk_tx_ctrl
  import extclk_ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      portEn,
  input  logic      txEn,
  input  logic      fallPulse,
  input  logic      holdFull,
  input  logic      holdNine,
  output txStrobe_t st
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic             busy;
  logic             curNine;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] lastIdx;
  logic             enable;
  logic             lastFall;

  assign enable   = portEn & txEn;
  assign lastIdx  = curNine ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  assign lastFall = busy & fallPulse & (bitCnt == lastIdx);

  always_comb begin
    st.clear = ~enable;
    st.load  = enable & holdFull & (~busy | lastFall);
    st.shift = enable & busy & fallPulse & ~st.load;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      curNine <= 1'b0;
      bitCnt  <= '0;
    end else if (st.clear) begin
      busy    <= 1'b0;
      bitCnt  <= '0;
    end else if (st.load) begin
      busy    <= 1'b1;
      curNine <= holdNine;
      bitCnt  <= '0;
    end else if (st.shift) begin
      if (lastFall) begin
        busy   <= 1'b0;
        bitCnt <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  // R4: the bit counter never runs past the word length
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt <= lastIdx));

  // R8: nothing stays busy once transmit is disabled
  p_idle_after_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy);
endmodule

// File: rtl/extclk_tx_dpath.sv
module extclk_tx_dpath
  import extclk_ser_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrNine,
  input  logic              wrBit9,
  input  txStrobe_t         st,
  output logic              holdFull,
  output logic              holdNine,
  output logic              dtOut
);
  localparam int SR_W = DATA_W + 1;

  logic [DATA_W-1:0] holdData;
  logic              holdBit9;
  logic [SR_W-1:0]   shiftReg;
  logic              wrAccept;

  assign wrAccept = wrStrobe & portEn;

  // holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdData <= '0;
      holdNine <= 1'b0;
      holdBit9 <= 1'b0;
    end else if (!portEn) begin
      holdFull <= 1'b0;
    end else begin
      holdFull <= wrAccept | (holdFull & ~st.load);
      if (wrAccept) begin
        holdData <= wrData;
        holdNine <= wrNine;
        holdBit9 <= wrBit9;
      end
    end
  end

  // shift register, ones fill in behind the data so the line idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         shiftReg <= '1;
    else if (st.clear) shiftReg <= '1;
    else if (st.load)  shiftReg <= {holdNine ? holdBit9 : 1'b1, holdData};
    else if (st.shift) shiftReg <= {1'b1, shiftReg[SR_W-1:1]};
  end

  assign dtOut = shiftReg[0];

  // R5: a waiting word stays until the control loads it
  p_held_until_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    (holdFull && !st.load && portEn) |=> holdFull);

  // R9: port disable empties the holding register
  p_port_off_empties_r9: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> !holdFull);

  // R8: the line returns to idle when disabled
  p_line_idle_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.clear |=> dtOut);

  // R3: the line only moves on a load or a shift
  p_line_moves_on_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!st.clear && !st.load && !st.shift) |=> $stable(dtOut));
endmodule

// File: rtl/extclk_ser_tx.sv
module extclk_ser_tx
  import extclk_ser_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ckIn,
  input  logic              portEn,
  input  logic              txEn,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrNine,
  input  logic              wrBit9,
  input  logic              intEn,
  output logic              dtOut,
  output logic              bufEmpty,
  output logic              txIrq
);
  logic      fallPulse;
  logic      holdFull;
  logic      holdNine;
  txStrobe_t st;

  extclk_ck_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .ckIn(ckIn), .fallPulse(fallPulse)
  );

  extclk_tx_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .portEn(portEn), .txEn(txEn),
    .fallPulse(fallPulse), .holdFull(holdFull), .holdNine(holdNine), .st(st)
  );

  extclk_tx_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .portEn(portEn), .wrStrobe(wrStrobe),
    .wrData(wrData), .wrNine(wrNine), .wrBit9(wrBit9), .st(st),
    .holdFull(holdFull), .holdNine(holdNine), .dtOut(dtOut)
  );

  assign bufEmpty = ~holdFull;
  assign txIrq    = intEn & bufEmpty;

  // R7: no request without the enable
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> intEn);
endmodule

// File: tb/tb_extclk_ser_tx.sv
module tb_extclk_ser_tx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ckIn = 1'b1;
  logic portEn = 1'b0, txEn = 1'b0, wrStrobe = 1'b0;
  logic [7:0] wrData = '0;
  logic wrNine = 1'b0, wrBit9 = 1'b0, intEn = 1'b0;
  logic dtOut, bufEmpty, txIrq;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  extclk_ser_tx dut (
    .clk(clk), .rstN(rstN), .ckIn(ckIn), .portEn(portEn), .txEn(txEn),
    .wrStrobe(wrStrobe), .wrData(wrData), .wrNine(wrNine), .wrBit9(wrBit9),
    .intEn(intEn), .dtOut(dtOut), .bufEmpty(bufEmpty), .txIrq(txIrq)
  );

  function automatic logic [8:0] expWord(logic [7:0] d, logic nine, logic b9);
    return {nine ? b9 : 1'b1, d};
  endfunction

  function automatic int wordLen(logic nine);
    return nine ? 9 : 8;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeWord(logic [7:0] d, logic nine, logic b9);
    wrData = d; wrNine = nine; wrBit9 = b9; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0;
  endtask

  // one remote bit period: sample on the rising side, then a falling edge
  task automatic clockWord(int n, output logic [8:0] got);
    got = '1;
    for (int i = 0; i < n; i++) begin
      got[i] = dtOut;
      ckIn = 1'b0;
      repeat (4) @(negedge clk);
      ckIn = 1'b1;
      repeat (4) @(negedge clk);
    end
  endtask

  logic [8:0] got;

  initial begin
    repeat (200000) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] a, b, c;
    logic n1, n2, x1, x2;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 bufEmpty", bufEmpty, 1);
    check("R1 dtOut", dtOut, 1);
    check("R1 txIrq", txIrq, 0);

    portEn = 1'b1; txEn = 1'b1;
    @(negedge clk);
    // R7 irq follows flag and enable
    intEn = 1'b1; #1;
    check("R7 irq on", txIrq, 1);

    // R2 single write
    writeWord(8'hA5, 1'b0, 1'b0);
    check("R2 full after write", bufEmpty, 0);
    check("R7 irq off when full", txIrq, 0);
    @(negedge clk);
    check("R2 empty after load", bufEmpty, 1);
    check("R2 bit0 on line", dtOut, 1);
    intEn = 1'b0; #1;
    check("R7 irq masked", txIrq, 0);
    clockWord(8, got);
    check("R3 lsb first word", got[7:0], 8'hA5);
    check("R3 idle after word", dtOut, 1);

    // R4 nine-bit word with ninth bit 0
    writeWord(8'h3C, 1'b1, 1'b0);
    @(negedge clk);
    clockWord(9, got);
    check("R4 nine-bit word", got, expWord(8'h3C, 1'b1, 1'b0));

    // R5 back to back
    writeWord(8'h81, 1'b0, 1'b0);
    writeWord(8'h7E, 1'b1, 1'b1);
    check("R5 flag low while held", bufEmpty, 0);
    clockWord(7, got);
    check("R5 flag still low before last edge", bufEmpty, 0);
    begin
      logic [8:0] tail;
      clockWord(1, tail);
      got[7] = tail[0];
    end
    check("R5 flag high after hand-off", bufEmpty, 1);
    check("R5 first word", got[7:0], 8'h81);
    clockWord(9, got);
    check("R5 second word no gap", got, expWord(8'h7E, 1'b1, 1'b1));

    // R6 overwrite
    writeWord(8'h11, 1'b0, 1'b0);
    writeWord(8'h22, 1'b0, 1'b0);
    writeWord(8'h33, 1'b0, 1'b0);
    check("R6 flag stays low", bufEmpty, 0);
    clockWord(8, got);
    check("R6 first word", got[7:0], 8'h11);
    clockWord(8, got);
    check("R6 replacement sent", got[7:0], 8'h33);
    clockWord(8, got);
    check("R6 nothing more", got[7:0], 8'hFF);

    // R8 abort and write before enable
    writeWord(8'h00, 1'b0, 1'b0);
    @(negedge clk);
    clockWord(3, got);
    txEn = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 line idle when off", dtOut, 1);
    writeWord(8'h96, 1'b0, 1'b0);
    clockWord(2, got);
    check("R8 held word kept", bufEmpty, 0);
    check("R8 no shift while off", got[1:0], 2'b11);
    txEn = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 load after enable", bufEmpty, 1);
    clockWord(8, got);
    check("R8 held word sent", got[7:0], 8'h96);

    // R9 port disable
    txEn = 1'b0;
    writeWord(8'h0F, 1'b0, 1'b0);
    portEn = 1'b0;
    @(negedge clk);
    check("R9 hold emptied", bufEmpty, 1);
    writeWord(8'h00, 1'b0, 1'b0);
    check("R9 write ignored", bufEmpty, 1);
    portEn = 1'b1; txEn = 1'b1;
    repeat (2) @(negedge clk);
    clockWord(8, got);
    check("R9 nothing sent", got[7:0], 8'hFF);

    // random mixed traffic
    for (int it = 0; it < 40; it++) begin
      a = 8'($urandom); b = 8'($urandom);
      n1 = 1'($urandom); n2 = 1'($urandom);
      x1 = 1'($urandom); x2 = 1'($urandom);
      writeWord(a, n1, x1);
      if ($urandom % 2) begin
        writeWord(b, n2, x2);
        clockWord(wordLen(n1), got);
        check("R5 random first", got, expWord(a, n1, x1) | (n1 ? 9'h000 : 9'h100));
        clockWord(wordLen(n2), got);
        check("R4 random second", got, expWord(b, n2, x2) | (n2 ? 9'h000 : 9'h100));
      end else begin
        @(negedge clk);
        clockWord(wordLen(n1), got);
        check("R3 random single", got, expWord(a, n1, x1) | (n1 ? 9'h000 : 9'h100));
      end
      c = 8'(it);
      if (c[3:0] == 4'd0) check("R2 random flag", bufEmpty, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule